// File: doc/BRIEF.md
# Periodic Tick Timer with Late-Service Catch-Up

This block produces a periodic tick interrupt from a free-running cycle counter. A 32-bit compare value is checked against the low half of the counter. When the two are equal, a pending flag is set and, if the mask allows it, the interrupt output rises. The flag holds until the handler acknowledges it. The handler may acknowledge late, even by several periods. On acknowledge the block counts the whole periods that have gone by since the expected tick time, using a multi-cycle divider. It reports that count with a one-cycle valid strobe.

The next tick is always placed on the original period grid, so late service never shifts the tick phase. If the next grid point lies too close to the current count to be reached safely, the compare is pushed one more period ahead. The tick lost this way is counted at the following service. A late flag goes up when the elapsed count exceeds a parameterized tick-rate limit.

Top module: `tick_catchup_timer`

## Requirements
- R1: In reset, `irq_o`, `ticks_vld_o`, `busy_o` and `late_o` are 0 and the counter is 0. On the first clock edge after reset is released, the compare and the stored expected time are both loaded with the count (0) plus `period_i`, so `cmp_o` equals `period_i` one cycle after release. The counter then advances by exactly 1 per cycle.
- R2: When the low 32 bits of the counter equal the compare value, a pending flag is set. `irq_o` is the pending flag gated by `irq_en_i`, and it rises in the cycle after the matching count.
- R3: Only an accepted acknowledge clears the pending flag. While `irq_en_i` is 0 the flag is kept, and `irq_o` rises as soon as the mask is lifted. A match on the same edge as an accepted acknowledge leaves the flag set.
- R4: `ack_i` is accepted only while the flag is pending and no computation is running. At any other time it has no effect: no computation starts, no result strobe appears and `cmp_o` is unchanged.
- R5: At an accepted acknowledge, `now` is the low 32 bits of the counter on that edge and `period_i` is sampled. `elapsed = (now - expected) mod 2^32`, and `ticks_o = 1 + floor(elapsed / period)`, 33 bits wide.
- R6: With `rem = elapsed mod period` and `gap = period - rem`, the new expected time is `now + gap` (mod 2^32). When `gap >= 8192`, `cmp_o` becomes exactly that value.
- R7: When `gap < 8192` (gap shifted right by 13 is zero), `cmp_o` becomes `now + gap + period`. The stored expected time is still `now + gap`, so the next service counts the skipped tick.
- R8: `late_o` is 1 when the reported tick count is greater than `LATE_LIM`, and 0 otherwise. It is updated with each result and held until the next one.
- R9: `busy_o` is 1 from the cycle after an accepted acknowledge until the result is written. `ticks_vld_o` is then a single-cycle pulse with `busy_o` already 0.
- R10: When `elapsed >> 5 < period`, the quotient is found by repeated subtraction; otherwise a bit-serial long division is used. Both paths give the same quotient and remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| period_i | input | 32 | Tick period in cycles, sampled at start and at each accepted acknowledge |
| irq_en_i | input | 1 | Interrupt mask (1 = enabled) |
| ack_i | input | 1 | Interrupt acknowledge / service request |
| irq_o | output | 1 | Tick interrupt (pending and enabled) |
| ticks_o | output | 33 | Whole periods elapsed, counted at the last service |
| ticks_vld_o | output | 1 | One-cycle strobe: a new `ticks_o` and `cmp_o` are ready |
| busy_o | output | 1 | Catch-up computation in progress |
| late_o | output | 1 | Last reported tick count exceeded the limit |
| cmp_o | output | 32 | Current compare value |

## Verification
The assertions assume a nonzero period that is well above the divider latency of about 35 cycles. They also assume that no acknowledge comes before the first interrupt. Under those conditions a freshly written compare always lies ahead of the counter.

The stimulus keeps to these limits. It uses periods of 10000 and 100 cycles, and it raises an acknowledge only after `irq_o` has been seen. The one exception is the deliberate stray acknowledge, sent while nothing is pending. The late acknowledges are timed so that all of the following occur at least once:
- a no-skip realignment;
- a skip;
- the catch-up service that follows a skip;
- the long-division path.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_SUB  = 2'd1,
        DV_LONG = 2'd2,
        DV_DONE = 2'd3
    } dv_state_e;

endpackage

// File: rtl/tick_free_counter.sv
module tick_free_counter #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned OUT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [OUT_W-1:0] cnt_lo_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_lo_o = cnt_q[OUT_W-1:0];

    // The visible low half advances by exactly one per cycle.
    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> cnt_lo_o == $past(cnt_lo_o) + OUT_W'(1));

endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import tick_timer_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned SUB_SH = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    localparam int unsigned SW      = $clog2(W + 1);
    localparam int unsigned SUB_MAX = (1 << SUB_SH) + 1;

    typedef struct packed {
        dv_state_e     st;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [SW-1:0] step;
    } dv_t;

    dv_t  dv_d, dv_q;
    logic [W:0] shl;
    logic       fits;

    always_comb begin
        dv_d = dv_q;
        shl  = {dv_q.rem, dv_q.quo[W-1]};
        fits = shl >= {1'b0, dv_q.dvs};
        case (dv_q.st)
            DV_IDLE: begin
                if (start_i) begin
                    dv_d.dvs  = dvs_i;
                    dv_d.step = '0;
                    if ((dvd_i >> SUB_SH) < dvs_i) begin
                        // short gap: a few subtractions are enough
                        dv_d.st  = DV_SUB;
                        dv_d.rem = dvd_i;
                        dv_d.quo = '0;
                    end else begin
                        // long gap: one quotient bit per cycle
                        dv_d.st  = DV_LONG;
                        dv_d.rem = '0;
                        dv_d.quo = dvd_i;
                    end
                end
            end
            DV_SUB: begin
                if (dv_q.rem >= dv_q.dvs) begin
                    dv_d.rem = dv_q.rem - dv_q.dvs;
                    dv_d.quo = dv_q.quo + W'(1);
                end else begin
                    dv_d.st = DV_DONE;
                end
            end
            DV_LONG: begin
                dv_d.rem  = fits ? (shl[W-1:0] - dv_q.dvs) : shl[W-1:0];
                dv_d.quo  = {dv_q.quo[W-2:0], fits};
                dv_d.step = dv_q.step + SW'(1);
                if (dv_q.step == SW'(W - 1)) dv_d.st = DV_DONE;
            end
            default: begin
                dv_d.st = DV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) dv_q <= '0;
        else         dv_q <= dv_d;
    end

    assign busy_o = dv_q.st != DV_IDLE;
    assign done_o = dv_q.st == DV_DONE;
    assign quo_o  = dv_q.quo;
    assign rem_o  = dv_q.rem;

    // R10: a finished division leaves a remainder below the divisor.
    assert_rem_below_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && dv_q.dvs != '0 |-> dv_q.rem < dv_q.dvs);

    // R10: the subtraction path is only chosen for small quotients.
    assert_sub_short_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dv_q.st == DV_SUB |-> dv_q.quo <= W'(SUB_MAX));

    // R9: the divider takes no new start while it is working.
    assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && !done_o |=> busy_o);

endmodule

// File: rtl/tick_realign.sv
module tick_realign #(
    parameter int unsigned W        = 32,
    parameter int unsigned SKIP_SH  = 13,
    parameter int unsigned LATE_LIM = 100
) (
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    output logic [W-1:0] next_o,
    output logic [W-1:0] cmp_o,
    output logic [W:0]   ticks_o,
    output logic         late_o
);

    logic [W-1:0] gap;
    logic         skip;

    always_comb begin
        gap     = per_i - rem_i;
        next_o  = now_i + gap;
        skip    = (gap >> SKIP_SH) == '0;
        cmp_o   = skip ? (next_o + per_i) : next_o;
        ticks_o = {1'b0, quo_i} + (W+1)'(1);
        late_o  = ticks_o > (W+1)'(LATE_LIM);
    end

endmodule

// File: rtl/tick_catchup_timer.sv
module tick_catchup_timer #(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned CMP_W    = 32,
    parameter int unsigned SUB_SH   = 5,
    parameter int unsigned SKIP_SH  = 13,
    parameter int unsigned LATE_LIM = 100
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CMP_W-1:0] period_i,
    input  logic             irq_en_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [CMP_W:0]   ticks_o,
    output logic             ticks_vld_o,
    output logic             busy_o,
    output logic             late_o,
    output logic [CMP_W-1:0] cmp_o
);

    localparam int unsigned TW = CMP_W + 1;

    typedef struct packed {
        logic             run;
        logic             pend;
        logic [CMP_W-1:0] cmp;
        logic [CMP_W-1:0] expct;
        logic [CMP_W-1:0] now;
        logic [CMP_W-1:0] per;
        logic [TW-1:0]    ticks;
        logic             vld;
        logic             late;
    } tt_t;

    tt_t tt_d, tt_q;

    logic [CMP_W-1:0] cnt_lo;
    logic             div_busy, div_done;
    logic [CMP_W-1:0] div_quo, div_rem;
    logic [CMP_W-1:0] ra_next, ra_cmp;
    logic [TW-1:0]    ra_ticks;
    logic             ra_late;
    logic             match, accept;

    tick_free_counter #(.CNT_W(CNT_W), .OUT_W(CMP_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cnt_lo_o (cnt_lo)
    );

    tick_divider #(.W(CMP_W), .SUB_SH(SUB_SH)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (accept),
        .dvd_i   (cnt_lo - tt_q.expct),
        .dvs_i   (period_i),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (div_quo),
        .rem_o   (div_rem)
    );

    tick_realign #(.W(CMP_W), .SKIP_SH(SKIP_SH), .LATE_LIM(LATE_LIM)) u_ra (
        .now_i   (tt_q.now),
        .per_i   (tt_q.per),
        .rem_i   (div_rem),
        .quo_i   (div_quo),
        .next_o  (ra_next),
        .cmp_o   (ra_cmp),
        .ticks_o (ra_ticks),
        .late_o  (ra_late)
    );

    always_comb begin
        tt_d     = tt_q;
        tt_d.vld = 1'b0;
        match    = tt_q.run && (cnt_lo == tt_q.cmp);
        accept   = tt_q.run && tt_q.pend && ack_i && !div_busy;

        if (!tt_q.run) begin
            // first cycle out of reset: arm one period ahead
            tt_d.run   = 1'b1;
            tt_d.cmp   = cnt_lo + period_i;
            tt_d.expct = cnt_lo + period_i;
        end

        if (accept) begin
            tt_d.now = cnt_lo;
            tt_d.per = period_i;
        end

        // a match wins over the clear, so no tick is dropped
        tt_d.pend = match || (tt_q.pend && !accept);

        if (div_done) begin
            tt_d.cmp   = ra_cmp;
            tt_d.expct = ra_next;
            tt_d.ticks = ra_ticks;
            tt_d.late  = ra_late;
            tt_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tt_q <= '0;
        else         tt_q <= tt_d;
    end

    assign irq_o       = tt_q.pend && irq_en_i;
    assign ticks_o     = tt_q.ticks;
    assign ticks_vld_o = tt_q.vld;
    assign busy_o      = div_busy;
    assign late_o      = tt_q.late;
    assign cmp_o       = tt_q.cmp;

    assert_match_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tt_q.run && cnt_lo == tt_q.cmp |=> tt_q.pend);

    assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tt_q.pend && !(ack_i && !busy_o) |=> tt_q.pend);

    assert_ack_noeffect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tt_q.run && ack_i && !tt_q.pend && !busy_o |=> !busy_o);

    assert_cmp_ahead_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_vld_o && tt_q.per > CMP_W'(CMP_W + 4)
        |-> (cmp_o - cnt_lo) != '0 && !(cmp_o - cnt_lo >= (CMP_W'(1) << (CMP_W - 1))));

    assert_vld_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_vld_o |=> !ticks_vld_o);

    assert_vld_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_vld_o |-> !busy_o);

endmodule

// File: tb/sim_tick_catchup_timer.sv
`timescale 1ns/1ps
module sim_tick_catchup_timer;

    localparam int unsigned LIM = 4;
    localparam logic [31:0] P0  = 32'd10000;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] period = P0;
    logic        irq_en = 1'b1;
    logic        ack = 1'b0;
    logic        irq_o, ticks_vld_o, busy_o, late_o;
    logic [32:0] ticks_o;
    logic [31:0] cmp_o;

    always #2.5 clk = ~clk;

    tick_catchup_timer #(.LATE_LIM(LIM)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .period_i    (period),
        .irq_en_i    (irq_en),
        .ack_i       (ack),
        .irq_o       (irq_o),
        .ticks_o     (ticks_o),
        .ticks_vld_o (ticks_vld_o),
        .busy_o      (busy_o),
        .late_o      (late_o),
        .cmp_o       (cmp_o)
    );

    logic [63:0] tb_cnt;
    always @(posedge clk) begin
        if (!rst_ni) tb_cnt <= '0;
        else         tb_cnt <= tb_cnt + 64'd1;
    end

    int checks = 0;
    int errors = 0;
    logic [31:0] b_exp;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic wait_irq();
        logic [31:0] c;
        int n;
        c = cmp_o;
        n = 0;
        while (!irq_o && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk("R2 irq rises one cycle after count equals compare", {32'd0, tb_cnt[31:0]}, {32'd0, c + 32'd1});
    endtask

    task automatic service(input int wait_n, input logic [31:0] per, input string tag);
        logic [31:0] now, el, q, r, gap, nxt, ecmp;
        logic [32:0] eticks;
        logic        skip, elate;
        int          n;
        repeat (wait_n) @(negedge clk);
        period = per;
        ack    = 1'b1;
        now    = tb_cnt[31:0];
        @(negedge clk);
        ack = 1'b0;
        chk({"R9 busy after accepted ack ", tag}, {63'd0, busy_o}, 64'd1);
        el     = now - b_exp;
        q      = el / per;
        r      = el % per;
        gap    = per - r;
        nxt    = now + gap;
        skip   = gap < 32'd8192;
        ecmp   = skip ? nxt + per : nxt;
        eticks = {1'b0, q} + 33'd1;
        elate  = eticks > 33'(LIM);
        n = 0;
        while (!ticks_vld_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk({"R9 result strobe seen ", tag}, {63'd0, ticks_vld_o}, 64'd1);
        chk({"R5 R10 ticks ", tag, ((el >> 5) < per) ? " sub path" : " long path"},
            {31'd0, ticks_o}, {31'd0, eticks});
        chk({skip ? "R7 skipped compare " : "R6 aligned compare ", tag}, {32'd0, cmp_o}, {32'd0, ecmp});
        chk({"R8 late flag ", tag}, {63'd0, late_o}, {63'd0, elate});
        chk({"R9 not busy with strobe ", tag}, {63'd0, busy_o}, 64'd0);
        @(negedge clk);
        chk({"R9 strobe is one cycle ", tag}, {63'd0, ticks_vld_o}, 64'd0);
        chk({"R8 late flag held ", tag}, {63'd0, late_o}, {63'd0, elate});
        b_exp = nxt;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1 irq in reset", {63'd0, irq_o}, 64'd0);
        chk("R1 strobe in reset", {63'd0, ticks_vld_o}, 64'd0);
        chk("R1 busy in reset", {63'd0, busy_o}, 64'd0);
        chk("R1 late in reset", {63'd0, late_o}, 64'd0);
        rst_ni = 1'b1;
        @(negedge clk);
        chk("R1 compare armed one period out", {32'd0, cmp_o}, {32'd0, P0});
        b_exp = P0;
    endtask

    task automatic t_mask();
        logic [31:0] c;
        int n;
        irq_en = 1'b0;
        c = cmp_o;
        n = 0;
        while (tb_cnt[31:0] != c + 32'd5 && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 masked irq stays low", {63'd0, irq_o}, 64'd0);
        irq_en = 1'b1;
        #1;
        chk("R3 pending kept and shown on unmask", {63'd0, irq_o}, 64'd1);
        service(0, P0, "after unmask");
    endtask

    task automatic t_stray_ack();
        logic [31:0] c;
        int seen;
        c = cmp_o;
        seen = 0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R4 stray ack starts nothing", {63'd0, busy_o}, 64'd0);
        repeat (50) begin
            @(negedge clk);
            if (ticks_vld_o) seen++;
        end
        chk("R4 stray ack gives no strobe", 64'(seen), 64'd0);
        chk("R4 stray ack keeps compare", {32'd0, cmp_o}, {32'd0, c});
    endtask

    initial begin
        t_reset();
        wait_irq();
        service(0, P0, "prompt");
        wait_irq();
        service(25000, P0, "late near next grid");
        wait_irq();
        service(0, P0, "catch-up after skip");
        wait_irq();
        service(21000, P0, "late far from grid");
        wait_irq();
        service(6000, 32'd100, "very late");
        wait_irq();
        service(0, 32'd100, "short period");
        wait_irq();
        service(0, P0, "period restored");
        t_mask();
        t_stray_ack();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule